// File: doc/BRIEF.md
# Watchdog-Driven Processor Reset Sequencer

This block drives the active-low reset of a microprocessor from a power-good level and a watchdog-clear strobe. A two-flop synchronizer brings in power-good. While the synchronized level is low, the clock-enable divider is held at zero and the processor reset is held asserted. When power-good goes high, the divider starts and produces a slow enable tick. A small watchdog counter advances on each tick. When its top bit would set, it emits a one-cycle terminal pulse and restarts from zero.

Each terminal pulse toggles a single reset flip-flop. The first pulse after power-up therefore releases the processor. After that, the running software must strobe the clear input often enough to keep the counter away from terminal count. If the strobes stop, the flip-flop keeps toggling, and the processor sees a square-wave reset that restarts it over and over until the clears resume.

Top module: `wdt_reset_seq`

## Requirements
- R1: While the synchronized power-good level is low, the divider is held cleared and `clk_en_o` never pulses. `pwr_ok_i` reaches the logic through two flops.
- R2: `cpu_rst_no` is 0 while the synchronized power-good is low. After `pwr_ok_i` falls, `cpu_rst_no` is 0 by the second rising clock edge.
- R3: After `pwr_ok_i` rises, `clk_en_o` first goes high after edge TICK_DIV+1, counting the first edge that samples the high level as edge 1. It is then high for one cycle in every TICK_DIV cycles.
- R4: After power-up, `cpu_rst_no` stays 0 until edge 8*TICK_DIV+3, counted the same way, and goes to 1 at that edge. This is the first terminal pulse, for the default 4-bit counter whose terminal value is 8.
- R5: A one-cycle `wd_clr_i` strobe while powered returns the watchdog count to zero. Strobes at intervals of at most 7*TICK_DIV cycles keep `cpu_rst_no` at 1 indefinitely.
- R6: A clear in the same cycle as the tick that would reach terminal count wins. No toggle follows, and the next toggle comes a full terminal period after that cycle.
- R7: With no clears, `cpu_rst_no` toggles every 8*TICK_DIV cycles, alternating between low and high phases of equal length.
- R8: `wd_clr_i` strobes while the synchronized power-good is low are ignored, and the release time of R4 is unchanged.
- R9: The terminal pulse lasts one cycle, and the counter restarts from zero after it.
- R10: A power-good drop during operation returns the block to the power-up state. The next rise repeats the R3 and R4 timing exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low flop initialisation |
| pwr_ok_i | input | 1 | Supply-good level, synchronized inside |
| wd_clr_i | input | 1 | Watchdog clear strobe from the processor |
| cpu_rst_no | output | 1 | Active-low processor reset |
| clk_en_o | output | 1 | Slow derived clock-enable tick |

## Verification
Every cycle, the assertions check the following: reset is held and the tick is quiet without power, a terminal pulse toggles reset and nothing else does, a powered clear suppresses the next terminal pulse, and that pulse is one cycle wide. Only the bench scenarios can show the absolute timing: the release edge after power-up, the toggle period of a stalled processor, and the fact that a steady stream of clears keeps reset high over a long run. The same holds for the clear-versus-terminal collision, which the bench times to the exact tick, and for the repeat of the power-up timing after a supply drop.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic {
        CPU_HELD = 1'b0,
        CPU_RUN  = 1'b1
    } cpu_state_e;

    function automatic cpu_state_e flip_state(input cpu_state_e s);
        return (s == CPU_HELD) ? CPU_RUN : CPU_HELD;
    endfunction

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_t;

    sync_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        state_d.chain[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            state_d.chain[i] = state_q.chain[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q_o = state_q.chain[STAGES-1];
endmodule

// File: rtl/rsq_divider.sv
module rsq_divider #(
    parameter int unsigned DIV = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_o
);
    localparam int unsigned DIV_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t state_d, state_q;
    logic wrap;

    assign wrap = (state_q.cnt == LAST);

    always_comb begin
        state_d = state_q;
        if (!run_i) begin
            state_d.cnt = '0;
        end else if (wrap) begin
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign tick_o = run_i && wrap;
endmodule

// File: rtl/rsq_wdog.sv
module rsq_wdog #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             term_o
);
    localparam logic [CNT_W-1:0] TERM     = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] PRE_TERM = TERM - 1'b1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             term;
    } wd_t;

    wd_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.term = 1'b0;
        if (!run_i || clr_i) begin
            state_d.cnt = '0;
        end else if (tick_i) begin
            if (state_q.cnt == PRE_TERM) begin
                state_d.cnt  = '0;
                state_d.term = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cnt_o  = state_q.cnt;
    assign term_o = state_q.term;
endmodule

// File: rtl/wdt_reset_seq.sv
module wdt_reset_seq #(
    parameter int unsigned TICK_DIV    = 1024,
    parameter int unsigned WD_WIDTH    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pwr_ok_i,
    input  logic wd_clr_i,
    output logic cpu_rst_no,
    output logic clk_en_o
);
    import rsq_pkg::*;

    logic                pg_sync;
    logic                div_tick;
    logic [WD_WIDTH-1:0] wd_cnt;
    logic                wd_term;

    typedef struct packed {
        cpu_state_e cpu;
    } top_t;

    top_t state_d, state_q;

    rsq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (pwr_ok_i),
        .q_o    (pg_sync)
    );

    rsq_divider #(.DIV(TICK_DIV)) u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (pg_sync),
        .tick_o (div_tick)
    );

    rsq_wdog #(.CNT_W(WD_WIDTH)) u_wdog (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (pg_sync),
        .tick_i (div_tick),
        .clr_i  (wd_clr_i),
        .cnt_o  (wd_cnt),
        .term_o (wd_term)
    );

    always_comb begin
        state_d = state_q;
        if (!pg_sync) begin
            state_d.cpu = CPU_HELD;
        end else if (wd_term) begin
            state_d.cpu = flip_state(state_q.cpu);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q.cpu <= CPU_HELD;
        end else begin
            state_q <= state_d;
        end
    end

    assign cpu_rst_no = (state_q.cpu == CPU_RUN) && pg_sync;
    assign clk_en_o   = div_tick;
endmodule

// File: rtl/wdt_reset_seq_chk.sv
module wdt_reset_seq_chk #(
    parameter int unsigned CNT_W = 4
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             pg_s,
    input logic             wd_clr_i,
    input logic             term,
    input logic [CNT_W-1:0] cnt,
    input logic             cpu_rst_no,
    input logic             clk_en_o
);
    AST_TICK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pg_s |-> !clk_en_o); // R1

    AST_HELD_NO_POWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pg_s |-> !cpu_rst_no); // R2

    AST_CLR_BLOCKS_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wd_clr_i && pg_s) |=> !term); // R6

    AST_TERM_TOGGLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (term && pg_s) |=> (!pg_s || (cpu_rst_no != $past(cpu_rst_no)))); // R7

    AST_STEADY_NO_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pg_s && !term) |=> (!pg_s || $stable(cpu_rst_no))); // R5

    AST_TERM_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term |=> !term); // R9

    AST_CNT_BELOW_TERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cnt[CNT_W-1]); // R9

    AST_NO_TERM_UNPOWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pg_s |=> !term); // R8
endmodule

bind wdt_reset_seq wdt_reset_seq_chk #(.CNT_W(WD_WIDTH)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pg_s       (pg_sync),
    .wd_clr_i   (wd_clr_i),
    .term       (wd_term),
    .cnt        (wd_cnt),
    .cpu_rst_no (cpu_rst_no),
    .clk_en_o   (clk_en_o)
);

// File: tb/wdt_reset_seq_bench.sv
`timescale 1ns/1ps
module wdt_reset_seq_bench;
    localparam int TD     = 8;
    localparam int PERIOD = 8 * TD;
    localparam int LAT    = 8 * TD + 3;

    logic clk_i = 1'b0;
    logic rst_ni = 1'b0;
    logic pwr_ok_i = 1'b0;
    logic wd_clr_i = 1'b0;
    logic cpu_rst_no;
    logic clk_en_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk_i = ~clk_i;

    wdt_reset_seq #(.TICK_DIV(TD)) u_wdt_reset_seq (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .pwr_ok_i   (pwr_ok_i),
        .wd_clr_i   (wd_clr_i),
        .cpu_rst_no (cpu_rst_no),
        .clk_en_o   (clk_en_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk_i);
        @(negedge clk_i);
    endtask

    task automatic wait_change(input int maxn, output int got);
        logic start;
        start = cpu_rst_no;
        got = -1;
        for (int n = 1; n <= maxn; n++) begin
            step();
            if (cpu_rst_no !== start) begin
                got = n;
                break;
            end
        end
    endtask

    // R3 R4 R10: timing of tick and release after power-good rises
    task automatic t_powerup(input bit clears_while_low, input string tag);
        int first_en, first_rel, gaps_bad, last_en;
        pwr_ok_i = 1'b0;
        for (int i = 0; i < 20; i++) begin
            wd_clr_i = clears_while_low ? ~wd_clr_i : 1'b0;   // R8 strobes while unpowered
            step();
            check(clk_en_o == 1'b0 && cpu_rst_no == 1'b0, "R1", clk_en_o, 0);
        end
        wd_clr_i = 1'b0;
        pwr_ok_i = 1'b1;
        first_en = 0; first_rel = 0; gaps_bad = 0; last_en = 0;
        for (int n = 1; n <= LAT + 2; n++) begin
            step();
            if (clk_en_o) begin
                if (first_en == 0) first_en = n;
                else if (n - last_en != TD) gaps_bad++;
                last_en = n;
            end
            if (cpu_rst_no && first_rel == 0) first_rel = n;
        end
        check(first_en == TD + 1, {"R3 first tick ", tag}, first_en, TD + 1);
        check(gaps_bad == 0, {"R3 tick spacing ", tag}, gaps_bad, 0);
        check(first_rel == LAT, {"R4 release edge ", tag}, first_rel, LAT);
    endtask

    // R5: periodic clears keep reset released
    task automatic t_clears_hold();
        int lows = 0;
        for (int n = 0; n < 1200; n++) begin
            wd_clr_i = (n % (7 * TD) == 0);
            step();
            if (!cpu_rst_no) lows++;
        end
        wd_clr_i = 1'b0;
        check(lows == 0, "R5 reset stayed high", lows, 0);
    endtask

    // R7 R9: stalled processor sees square-wave reset
    task automatic t_stall();
        int got;
        wait_change(3 * PERIOD, got);
        check(got > 0 && cpu_rst_no == 1'b0, "R7 first drop", got, 1);
        for (int k = 0; k < 4; k++) begin
            wait_change(3 * PERIOD, got);
            check(got == PERIOD, "R7 toggle period", got, PERIOD);
        end
    endtask

    // R6: clear in the terminal tick cycle wins
    task automatic t_clear_priority();
        int got;
        wait_change(3 * PERIOD, got);
        for (int i = 0; i < PERIOD - 2; i++) step();
        wd_clr_i = 1'b1;
        step();
        wd_clr_i = 1'b0;
        wait_change(3 * PERIOD, got);
        check(got == PERIOD + 1, "R6 clear beats terminal", got, PERIOD + 1);
    endtask

    // R2: supply drop forces reset within two edges
    task automatic t_drop();
        wd_clr_i = 1'b0;
        pwr_ok_i = 1'b0;
        step();
        step();
        check(cpu_rst_no == 1'b0, "R2 reset after drop", cpu_rst_no, 0);
        check(clk_en_o == 1'b0, "R1 tick stopped", clk_en_o, 0);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) step();
        check(cpu_rst_no == 1'b0, "R2 reset state", cpu_rst_no, 0);
        check(clk_en_o == 1'b0, "R1 reset state", clk_en_o, 0);
        rst_ni = 1'b1;
        step();
        t_powerup(1'b0, "cold");
        t_clears_hold();
        t_stall();
        t_clear_priority();
        t_drop();
        t_powerup(1'b1, "R8 clears ignored");
        t_drop();
        t_powerup(1'b0, "R10 repeat");
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk_i);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule